// File: doc/BRIEF.md
# Programmable System Watchdog Timer

This block is a watchdog for a system that must be restarted if its software stops responding. A down-counter, advanced by a slow tick-enable pulse from an external prescaler, counts toward zero from a programmed initial value. Software proves it is alive by writing the reload register, which restarts the count. If the count runs out once, a timeout flag is raised and the counter starts again. If it runs out a second time before software clears that flag, the block may issue a one-cycle system reset request. A separate gate bit, set out of reset, can block that request.

The block is reached through a small register bus with word-wide accesses. Writes take effect at the clock edge where `wr_en` is sampled. A read loads `rdata` at the edge where `rd_en` is sampled, and `rdata` holds that value until the next read. One tick lasts 0.6 s, so a timeout of S seconds is programmed as S*10/6 ticks. The default of 50 ticks gives roughly 30 seconds.

A four-state machine sequences the expiry behaviour. The states are HALTED, RUN, WARN and BITE. The transitions are:
- start: HALTED to RUN, or to WARN if the timeout flag is still set.
- first-expiry: RUN to WARN.
- acknowledge: WARN to RUN once the flag is cleared.
- second-expiry: WARN to BITE.
- bite-done: BITE to WARN after one cycle.
- stop: any state to HALTED while the halt bit is 1.

Top module: `sys_watchdog`

## Requirements
- R1: After reset the halt bit is 1, the no-reboot gate is 1, the stored initial count and the live counter are both 50, all status bits are 0, and `timeout_o` and `rst_req_o` are low.
- R2: A write to the initial-value register (offset 0x12) always stores bits [15:10] as written. It stores bits [9:0] as the new count only if that value is 4 or more; values 0 to 3 leave the stored count unchanged. A read returns both fields.
- R3: Any write to offset 0x00 reloads the counter from the stored initial count, whatever the data. A read of 0x00 returns the live count in bits [9:0], with zeros above.
- R4: Bit 11 of the control register (offset 0x08) is the halt bit and reads back as written; every other bit of that register reads 0. While the block is halted, the counter holds its value and no expiry occurs.
- R5: While the block runs, each cycle with `tick_en` high lowers the count by one. A tick that finds the count at 0 is an expiry and reloads the initial count, so with count N the expiry falls on the (N+1)th tick after a reload.
- R6: The first expiry sets the timeout flag, which is bit 3 of offset 0x04, and `timeout_o` follows that flag.
- R7: An expiry while the timeout flag is set sets bit 1 of offset 0x06. If the no-reboot gate is 0 it also raises `rst_req_o` for exactly one cycle and sets bit 0 of 0x06. If the gate is 1, no request is raised.
- R8: The no-reboot gate is bit 0 of offset 0x0C and reads back as written, including 0.
- R9: Status bits are write-1-to-clear. Writing 0 leaves them unchanged, and writing 3 to offset 0x06 clears both of its bits.
- R10: A reload write in the same cycle as an expiring tick takes priority: the counter loads the initial count and no expiry is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per watchdog tick |
| addr | input | 5 | Register byte offset |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Read data, updated by a read and then held |
| timeout_o | output | 1 | First-expiry timeout flag |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two functions can land on the same edge: a software reload write, and the tick that finds the counter at zero. The bench first brings the counter to zero with single ticks and reads it back to confirm the value. It then drives the reload write and the tick together for one cycle. Afterwards the counter must read the stored initial count, `timeout_o` must still be low, and the next tick must lower the count by one, which shows that reload took priority and no expiry was recorded.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // register byte offsets
    localparam int OFS_RELOAD = 'h00;
    localparam int OFS_STAT_A = 'h04;
    localparam int OFS_STAT_B = 'h06;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_GATE   = 'h0C;
    localparam int OFS_INIT   = 'h12;

    // bit positions inside registers
    localparam int HALT_BIT   = 11;
    localparam int TMO_BIT    = 3;
    localparam int SECOND_BIT = 1;
    localparam int BITE_BIT   = 0;
    localparam int GATE_BIT   = 0;

    typedef enum logic [1:0] {
        WD_HALTED = 2'd0,
        WD_RUN    = 2'd1,
        WD_WARN   = 2'd2,
        WD_BITE   = 2'd3
    } wd_state_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 5,
    parameter int CNT_W        = 10,
    parameter int INIT_DEFAULT = 50,
    parameter int MIN_LOAD     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              set_tmo,
    input  logic              set_second,
    input  logic              set_bite,
    output logic [DATA_W-1:0] rdata,
    output logic              halt,
    output logic              noreboot,
    output logic              tmo_flag,
    output logic              reload_wr,
    output logic [CNT_W-1:0]  init_cnt
);

    localparam int HI_W = DATA_W - CNT_W;
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_STAT_A = ADDR_W'(OFS_STAT_A);
    localparam logic [ADDR_W-1:0] A_STAT_B = ADDR_W'(OFS_STAT_B);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_GATE   = ADDR_W'(OFS_GATE);
    localparam logic [ADDR_W-1:0] A_INIT   = ADDR_W'(OFS_INIT);
    localparam logic [CNT_W-1:0]  MIN_L    = CNT_W'(MIN_LOAD);
    localparam logic [CNT_W-1:0]  INIT_L   = CNT_W'(INIT_DEFAULT);

    logic            wr_stat_a, wr_stat_b, wr_ctrl, wr_gate, wr_init;
    logic [HI_W-1:0] init_hi;
    logic            second_flag, bite_flag;
    logic [DATA_W-1:0] rd_next;

    assign reload_wr = wr_en && (addr == A_RELOAD);
    assign wr_stat_a = wr_en && (addr == A_STAT_A);
    assign wr_stat_b = wr_en && (addr == A_STAT_B);
    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign wr_gate   = wr_en && (addr == A_GATE);
    assign wr_init   = wr_en && (addr == A_INIT);

    // initial value: upper field always written, count only when legal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_hi  <= '0;
            init_cnt <= INIT_L;
        end else if (wr_init) begin
            init_hi <= wdata[DATA_W-1:CNT_W];
            if (wdata[CNT_W-1:0] >= MIN_L)
                init_cnt <= wdata[CNT_W-1:0];
        end
    end

    // control and gate bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt     <= 1'b1;
            noreboot <= 1'b1;
        end else begin
            if (wr_ctrl) halt     <= wdata[HALT_BIT];
            if (wr_gate) noreboot <= wdata[GATE_BIT];
        end
    end

    // status flags: hardware set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_flag    <= 1'b0;
            second_flag <= 1'b0;
            bite_flag   <= 1'b0;
        end else begin
            if (set_tmo)
                tmo_flag <= 1'b1;
            else if (wr_stat_a && wdata[TMO_BIT])
                tmo_flag <= 1'b0;

            if (set_second)
                second_flag <= 1'b1;
            else if (wr_stat_b && wdata[SECOND_BIT])
                second_flag <= 1'b0;

            if (set_bite)
                bite_flag <= 1'b1;
            else if (wr_stat_b && wdata[BITE_BIT])
                bite_flag <= 1'b0;
        end
    end

    // read multiplexer
    always_comb begin
        rd_next = '0;
        case (addr)
            A_RELOAD: rd_next[CNT_W-1:0] = cnt;
            A_STAT_A: rd_next[TMO_BIT] = tmo_flag;
            A_STAT_B: begin
                rd_next[SECOND_BIT] = second_flag;
                rd_next[BITE_BIT]   = bite_flag;
            end
            A_CTRL:   rd_next[HALT_BIT] = halt;
            A_GATE:   rd_next[GATE_BIT] = noreboot;
            A_INIT:   rd_next = {init_hi, init_cnt};
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W        = 10,
    parameter int INIT_DEFAULT = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_cnt,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam logic [CNT_W-1:0] INIT_L = CNT_W'(INIT_DEFAULT);

    logic at_zero;

    assign at_zero = (cnt == '0);
    // software reload masks an expiry in the same cycle
    assign expire  = run && tick && at_zero && !reload;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= INIT_L;
        else if (reload)
            cnt <= init_cnt;
        else if (run && tick) begin
            if (at_zero)
                cnt <= init_cnt;
            else
                cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic tmo_flag,
    input  logic expire,
    input  logic noreboot,
    output logic run,
    output logic set_tmo,
    output logic set_second,
    output logic set_bite,
    output logic rst_req
);

    wd_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= WD_HALTED;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            WD_HALTED: begin
                if (!halt)
                    state_nx = tmo_flag ? WD_WARN : WD_RUN;      // start
            end
            WD_RUN: begin
                if (halt)
                    state_nx = WD_HALTED;                        // stop
                else if (expire)
                    state_nx = WD_WARN;                          // first-expiry
            end
            WD_WARN: begin
                if (halt)
                    state_nx = WD_HALTED;                        // stop
                else if (expire)
                    state_nx = WD_BITE;                          // second-expiry
                else if (!tmo_flag)
                    state_nx = WD_RUN;                           // acknowledge
            end
            WD_BITE: begin
                state_nx = halt ? WD_HALTED : WD_WARN;           // stop / bite-done
            end
            default: state_nx = WD_HALTED;
        endcase
    end

    // outputs
    always_comb begin
        run        = (state != WD_HALTED);
        set_tmo    = (state == WD_RUN)  && expire;
        set_second = (state == WD_WARN) && expire;
        rst_req    = (state == WD_BITE) && !noreboot;
        set_bite   = rst_req;
    end

endmodule

// File: rtl/sys_watchdog.sv
module sys_watchdog #(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 5,
    parameter int CNT_W        = 10,
    parameter int INIT_DEFAULT = 50,
    parameter int MIN_LOAD     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout_o,
    output logic              rst_req_o
);

    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] init_cnt;
    logic             halt, noreboot, tmo_flag, reload_wr;
    logic             run, expire;
    logic             set_tmo, set_second, set_bite;

    wdog_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .INIT_DEFAULT(INIT_DEFAULT), .MIN_LOAD(MIN_LOAD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .cnt(cnt_val),
        .set_tmo(set_tmo), .set_second(set_second), .set_bite(set_bite),
        .rdata(rdata), .halt(halt), .noreboot(noreboot),
        .tmo_flag(tmo_flag), .reload_wr(reload_wr), .init_cnt(init_cnt)
    );

    wdog_counter #(
        .CNT_W(CNT_W), .INIT_DEFAULT(INIT_DEFAULT)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_en),
        .reload(reload_wr), .init_cnt(init_cnt),
        .cnt(cnt_val), .expire(expire)
    );

    wdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt(halt), .tmo_flag(tmo_flag),
        .expire(expire), .noreboot(noreboot), .run(run),
        .set_tmo(set_tmo), .set_second(set_second),
        .set_bite(set_bite), .rst_req(rst_req_o)
    );

    assign timeout_o = tmo_flag;

endmodule

// File: rtl/sys_watchdog_chk.sv
module sys_watchdog_chk #(
    parameter int CNT_W    = 10,
    parameter int MIN_LOAD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rst_req,
    input logic             timeout,
    input logic             noreboot,
    input logic             run,
    input logic             expire,
    input logic             reload_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] init_cnt
);

    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7
    rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !noreboot);

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload_wr) |=> (cnt == $past(cnt)));

    // R6
    tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !wr_en) |=> timeout);

    // R10
    reload_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (cnt == $past(init_cnt)));

    // R2
    init_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_cnt >= CNT_W'(MIN_LOAD));

endmodule

bind sys_watchdog sys_watchdog_chk #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rst_req(rst_req_o),
    .timeout(timeout_o), .noreboot(noreboot), .run(run), .expire(expire),
    .reload_wr(reload_wr), .cnt(cnt_val), .init_cnt(init_cnt)
);

// File: tb/test_sys_watchdog.sv
module test_sys_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        timeout_o;
    logic        rst_req_o;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    int long_pulses = 0;
    logic prev_req = 1'b0;

    always #4 clk = ~clk;

    sys_watchdog i_sys_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .timeout_o(timeout_o), .rst_req_o(rst_req_o)
    );

    // count reset-request pulses and any that last longer than a cycle
    always @(posedge clk) begin
        if (rst_req_o) pulses <= pulses + 1;
        if (rst_req_o && prev_req) long_pulses <= long_pulses + 1;
        prev_req <= rst_req_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 timeout_o", int'(timeout_o), 0);
        chk("R1 rst_req_o", int'(rst_req_o), 0);
        rd(5'h00, d); chk("R1 live count", int'(d), 50);
        rd(5'h12, d); chk("R1 init value", int'(d), 50);
        rd(5'h08, d); chk("R1 halt bit", int'(d), 'h0800);
        rd(5'h0C, d); chk("R1 no-reboot gate", int'(d), 1);
        rd(5'h04, d); chk("R1 status A", int'(d), 0);
        rd(5'h06, d); chk("R1 status B", int'(d), 0);
    endtask

    task automatic t_init_value();
        logic [15:0] d;
        wr(5'h12, 16'hFC05);
        rd(5'h12, d); chk("R2 legal write", int'(d), 'hFC05);
        wr(5'h12, 16'h0003);
        rd(5'h12, d); chk("R2 illegal count kept, upper field written", int'(d), 'h0005);
        wr(5'h00, 16'h1234);
        rd(5'h00, d); chk("R3 reload from init", int'(d), 5);
    endtask

    task automatic t_halted();
        logic [15:0] d;
        ticks(8);
        rd(5'h00, d); chk("R4 halted counter holds", int'(d), 5);
        chk("R4 no expiry while halted", int'(timeout_o), 0);
    endtask

    task automatic t_run_and_expire();
        logic [15:0] d;
        wr(5'h08, 16'h0000);
        rd(5'h08, d); chk("R4 halt readback 0", int'(d), 0);
        ticks(3);
        rd(5'h00, d); chk("R5 decrement per tick", int'(d), 2);
        ticks(2);
        rd(5'h00, d); chk("R5 count at zero", int'(d), 0);
        chk("R6 no timeout before expiry", int'(timeout_o), 0);
        ticks(1);
        chk("R6 timeout_o after first expiry", int'(timeout_o), 1);
        rd(5'h00, d); chk("R5 reload on expiry", int'(d), 5);
        rd(5'h04, d); chk("R6 status A bit 3", int'(d), 'h0008);
        chk("R7 no request on first expiry", pulses, 0);
    endtask

    task automatic t_second_gated();
        logic [15:0] d;
        ticks(5);
        rd(5'h06, d); chk("R7 status B before second expiry", int'(d), 0);
        ticks(1);
        repeat (2) @(negedge clk);
        rd(5'h06, d); chk("R7 second expiry flag, gated", int'(d), 'h0002);
        chk("R7 request blocked by gate", pulses, 0);
        wr(5'h04, 16'h0000);
        chk("R9 write 0 leaves status", int'(timeout_o), 1);
        wr(5'h06, 16'h0003);
        rd(5'h06, d); chk("R9 write 3 clears status B", int'(d), 0);
        wr(5'h04, 16'h0008);
        chk("R9 write 1 clears timeout", int'(timeout_o), 0);
    endtask

    task automatic t_second_reboot();
        logic [15:0] d;
        wr(5'h0C, 16'h0000);
        rd(5'h0C, d); chk("R8 gate reads 0", int'(d), 0);
        wr(5'h00, 16'h0000);
        ticks(6);
        chk("R6 first expiry again", int'(timeout_o), 1);
        chk("R7 no request on first expiry", pulses, 0);
        ticks(6);
        repeat (2) @(negedge clk);
        chk("R7 one request pulse", pulses, 1);
        chk("R7 pulse lasts one cycle", long_pulses, 0);
        rd(5'h06, d); chk("R7 status B both bits", int'(d), 'h0003);
        wr(5'h06, 16'h0003);
        wr(5'h04, 16'h0008);
        rd(5'h06, d); chk("R9 status B cleared", int'(d), 0);
        chk("R9 timeout cleared", int'(timeout_o), 0);
    endtask

    task automatic t_collision();
        logic [15:0] d;
        @(negedge clk);
        wr(5'h00, 16'h0000);
        ticks(5);
        rd(5'h00, d); chk("R10 count at zero before collision", int'(d), 0);
        addr = 5'h00; wdata = 16'h0000; wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        chk("R10 no expiry on collision", int'(timeout_o), 0);
        rd(5'h00, d); chk("R10 reload wins", int'(d), 5);
        ticks(1);
        rd(5'h00, d); chk("R10 still running", int'(d), 4);
    endtask

    task automatic t_halt_again();
        logic [15:0] d;
        wr(5'h08, 16'hFFFF);
        rd(5'h08, d); chk("R4 only halt bit reads", int'(d), 'h0800);
        ticks(10);
        rd(5'h00, d); chk("R4 count frozen", int'(d), 4);
        chk("R4 no timeout while halted", int'(timeout_o), 0);
        wr(5'h0C, 16'h0001);
        rd(5'h0C, d); chk("R8 gate reads 1", int'(d), 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_value();
        t_halted();
        t_run_and_expire();
        t_second_gated();
        t_second_reboot();
        t_collision();
        t_halt_again();
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule